// File: doc/BRIEF.md
# UART Transmit Framer

This block turns characters from a small on-chip queue into asynchronous serial frames on a single output line. The host pushes characters through a write port and configures the frame shape with a mode word: character length (8, 7 or 6 bits), parity (even, odd, forced-zero, forced-one or none) and one or two stop bits. A separate baud-rate enable tick, generated elsewhere, sets the bit rate. Each bit on the line lasts exactly one tick interval.

A control word, applied with a one-cycle strobe, enables or disables the transmitter, flushes the transmit logic, and starts or stops a break (line held low). Status outputs report when the queue is empty and when it is full. Disable and break requests never cut a frame short. They take hold at the next frame boundary.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is high, the FIFO reports empty and not full, the transmitter is disabled and no break is active.
- R2: A frame is sent least significant bit first as one low start bit, the data bits, the optional parity bit and then high stop bits. Each bit lasts one baud tick. With mode 8'h20 (8 data bits, no parity, one stop bit) a frame is 10 bits long.
- R3: mode[2:1] selects the character length: 00 gives 8 data bits, 10 gives 7 and 11 gives 6. Unused upper bits of the written character are not sent.
- R4: mode[5:3] selects parity: 000 even (the total count of ones in data and parity is even), 001 odd, 010 parity bit always 0, 011 parity bit always 1, and 1xx sends no parity bit.
- R5: mode[7:6] = 10 sends two stop bits. Any other value sends one.
- R6: Control bit 4 enables the transmitter and control bit 5 disables it. Disable wins when both are set. While disabled no frame starts, queued characters are kept and the line stays high.
- R7: A disable issued during a frame lets that frame complete intact. No further frame starts after it.
- R8: Control bit 7 starts a break and control bit 8 ends it. Bit 8 wins when both are set. While the break is active and no frame is in flight, the line is low and no frame starts. A break issued during a frame takes hold only after the frame's last stop bit.
- R9: Control bit 1 empties the FIFO and aborts any frame in progress. In the next cycle the FIFO reports empty, and the line is high unless a break is active.
- R10: The FIFO holds 16 characters and sends them in write order. The full flag is raised at 16 entries, and a write while full is dropped.
- R11: When further characters are queued and the transmitter stays enabled, the next start bit directly follows the last stop bit, with no idle bit between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle bit-rate enable |
| wrEn | input | 1 | Push `wrData` into the transmit FIFO |
| wrData | input | 8 | Character to queue |
| ctrlWr | input | 1 | Apply `ctrlWord` this cycle |
| ctrlWord | input | 9 | Command bits: 1 flush, 4 enable, 5 disable, 7 break on, 8 break off |
| mode | input | 8 | Frame format: [2:1] length, [5:3] parity, [7:6] stop bits |
| txLine | output | 1 | Serial output, idles high |
| fifoEmpty | output | 1 | Transmit FIFO holds no characters |
| fifoFull | output | 1 | Transmit FIFO holds 16 characters |

## Verification
The bench builds the block with its default parameters: 8-bit characters and a 16-entry queue. It drives a baud tick every fourth clock. With this depth the full flag and the dropped seventeenth write are reached within a few dozen cycles. The 8-bit width makes the longest 12-bit frame (8 data, parity, two stops) and both shortened lengths observable. The slow tick leaves several clocks inside each bit, so disable, break and flush commands can land in the middle of a frame and their deferred or immediate effect shows up on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // control word bit positions
  localparam int CTL_TXRST   = 1;
  localparam int CTL_EN      = 4;
  localparam int CTL_DIS     = 5;
  localparam int CTL_BRK_ON  = 7;
  localparam int CTL_BRK_OFF = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;    // empty queue, abort frame
    logic load;     // pop head, start a new frame
    logic advance;  // move to next bit of current frame
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strobe,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        mode,
  input  logic              brkOn,
  output logic              txLine,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              busy,
  output logic              lastBit
);

  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int FRAME_W = DATA_W + 4;
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  // ---------------- transmit FIFO ----------------
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign push      = wrEn & ~fifoFull & ~strobe.flush;
  assign pop       = strobe.load;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // ---------------- frame builder ----------------
  logic [DATA_W-1:0]  headData, dataMasked;
  logic [BITS_W-1:0]  nData, frameLen;
  logic [FRAME_W-1:0] frame;
  logic               parOn, parBit, twoStop;
  logic               unusedModeBit;

  assign headData      = mem[rdPtr];
  assign unusedModeBit = mode[0];

  always_comb begin
    case (mode[2:1])
      2'b10:   nData = BITS_W'(DATA_W - 1);
      2'b11:   nData = BITS_W'(DATA_W - 2);
      default: nData = BITS_W'(DATA_W);
    endcase
    dataMasked = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(nData)) dataMasked[i] = headData[i];
    parOn = ~mode[5];
    case (mode[4:3])
      2'b00:   parBit = ^dataMasked;
      2'b01:   parBit = ~^dataMasked;
      2'b10:   parBit = 1'b0;
      default: parBit = 1'b1;
    endcase
    twoStop = (mode[7:6] == 2'b10);
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(nData)) frame[i+1] = headData[i];
    for (int i = 0; i <= DATA_W; i++)
      if (parOn && i == int'(nData)) frame[i+1] = parBit;
    frameLen = BITS_W'(2) + nData + BITS_W'(parOn) + BITS_W'(twoStop);
  end

  // ---------------- bit sequencer ----------------
  logic [FRAME_W-1:0] shiftReg;
  logic [BITS_W-1:0]  bitsLeft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '1;
      bitsLeft <= '0;
    end else if (strobe.flush) begin
      shiftReg <= '1;
      bitsLeft <= '0;
    end else if (strobe.load) begin
      shiftReg <= frame;
      bitsLeft <= frameLen;
    end else if (strobe.advance) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign busy    = (bitsLeft != '0);
  assign lastBit = (bitsLeft == BITS_W'(1));
  assign txLine  = busy ? shiftReg[0] : ~brkOn;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && fifoFull && !pop && !strobe.flush) |=> (fifoFull && count == $past(count)));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flush |=> (fifoEmpty && !busy));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (busy && !txLine));

  // R11
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |-> !fifoEmpty);

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int CTRL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baudTick,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              fifoEmpty,
  input  logic              busy,
  input  logic              lastBit,
  output txStrobe_t         strobe,
  output logic              brkOn
);

  logic txEn, flushReq, frameDone, unusedCtrlBits;

  assign unusedCtrlBits = ^{ctrlWord[0], ctrlWord[3:2], ctrlWord[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txEn  <= 1'b0;
      brkOn <= 1'b0;
    end else if (ctrlWr) begin
      if (ctrlWord[CTL_DIS])     txEn <= 1'b0;
      else if (ctrlWord[CTL_EN]) txEn <= 1'b1;
      if (ctrlWord[CTL_BRK_OFF])     brkOn <= 1'b0;
      else if (ctrlWord[CTL_BRK_ON]) brkOn <= 1'b1;
    end
  end

  assign flushReq  = ctrlWr & ctrlWord[CTL_TXRST];
  assign frameDone = ~busy | lastBit;

  always_comb begin
    strobe.flush   = flushReq;
    strobe.load    = baudTick & frameDone & txEn & ~brkOn & ~fifoEmpty & ~flushReq;
    strobe.advance = baudTick & busy & ~strobe.load & ~flushReq;
  end

  // R6
  dis_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWr && ctrlWord[CTL_DIS]) |=> !txEn);

  // R7
  no_midframe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lastBit) |-> !strobe.load);

  // R8
  brk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWr && ctrlWord[CTL_BRK_OFF]) |=> !brkOn);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CTRL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baudTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [7:0]        mode,
  output logic              txLine,
  output logic              fifoEmpty,
  output logic              fifoFull
);

  txStrobe_t strobe;
  logic      brkOn, busy, lastBit;

  uart_tx_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick),
    .ctrlWr(ctrlWr), .ctrlWord(ctrlWord), .fifoEmpty(fifoEmpty),
    .busy(busy), .lastBit(lastBit), .strobe(strobe), .brkOn(brkOn)
  );

  uart_tx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrEn(wrEn), .wrData(wrData), .mode(mode), .brkOn(brkOn),
    .txLine(txLine), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .busy(busy), .lastBit(lastBit)
  );

endmodule

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       ctrlWr = 1'b0;
  logic [8:0] ctrlWord = '0;
  logic [7:0] mode = 8'h20;
  logic       txLine, fifoEmpty, fifoFull;

  int checks = 0;
  int fails  = 0;

  logic cap [0:1023];
  int   nb = 0;

  always #2.5 clk = ~clk;

  uart_tx_framer i_uart_tx_framer (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick),
    .wrEn(wrEn), .wrData(wrData), .ctrlWr(ctrlWr), .ctrlWord(ctrlWord),
    .mode(mode), .txLine(txLine), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );

  // baud tick every 4 clocks, driven just after the edge
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      baudTick = (cnt == 3);
      cnt = (cnt + 1) % 4;
    end
  end

  // record the line bit that each tick ends
  always @(negedge clk) begin
    if (baudTick) begin
      if (nb < 1024) cap[nb] = txLine;
      nb = nb + 1;
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int findZero(int from);
    for (int i = from; i < nb && i < 1024; i++)
      if (!cap[i]) return i;
    return -1;
  endfunction

  function automatic int getBits(int at, int n);
    int v = 0;
    for (int i = 0; i < n; i++) if (cap[at+i]) v = v | (1 << i);
    return v;
  endfunction

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1; wrEn = 1'b1; wrData = d;
    @(posedge clk); #1; wrEn = 1'b0;
  endtask

  task automatic ctl(input logic [8:0] c);
    @(posedge clk); #1; ctrlWr = 1'b1; ctrlWord = c;
    @(posedge clk); #1; ctrlWr = 1'b0; ctrlWord = '0;
  endtask

  task automatic waitTicks(input int n);
    repeat (n * 4) @(posedge clk);
  endtask

  task automatic waitStart();
    do @(negedge clk); while (txLine);
  endtask

  // flush, disable, end break
  task automatic clean(input logic [7:0] m);
    ctl(9'h122);
    mode = m;
    @(posedge clk); #1;
    nb = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chkEq("R1 line high", txLine, 1);
    chkEq("R1 empty", fifoEmpty, 1);
    chkEq("R1 not full", fifoFull, 0);
    wr(8'h11);
    waitTicks(15);
    chkEq("R1 disabled after reset", findZero(0), -1);
    ctl(9'h002);
  endtask

  task automatic frameTest(input string tag, input logic [7:0] m, input logic [7:0] d,
                           input int n, input int hp, input int ep, input int ns, input int ed);
    int s;
    clean(m);
    ctl(9'h010);
    wr(d);
    waitTicks(n + 8);
    s = findZero(0);
    chkEq({tag, " start"}, int'(s >= 0), 1);
    if (s < 0) return;
    chkEq({tag, " data"}, getBits(s + 1, n), ed);
    if (hp != 0) chkEq({tag, " parity"}, int'(cap[s+1+n]), ep);
    for (int k = 0; k < ns; k++) chkEq({tag, " stop"}, int'(cap[s+1+n+hp+k]), 1);
    chkEq({tag, " idle after"}, findZero(s + 1 + n + hp + ns), -1);
  endtask

  task automatic t_8n1_b2b();
    int s;
    clean(8'h20);
    ctl(9'h010);
    wr(8'hA5); wr(8'h3C);
    waitTicks(28);
    s = findZero(0);
    chkEq("R2 first data", getBits(s + 1, 8), 8'hA5);
    chkEq("R2 stop", int'(cap[s+9]), 1);
    chkEq("R11 next start adjacent", int'(cap[s+10]), 0);
    chkEq("R11 second data", getBits(s + 11, 8), 8'h3C);
    chkEq("R2 idle after", findZero(s + 20), -1);
    chkEq("R10 drained", fifoEmpty, 1);
  endtask

  task automatic t_two_stop();
    int s;
    clean(8'hA0);
    ctl(9'h010);
    wr(8'h0F); wr(8'hF0);
    waitTicks(30);
    s = findZero(0);
    chkEq("R5 data", getBits(s + 1, 8), 8'h0F);
    chkEq("R5 stop1", int'(cap[s+9]), 1);
    chkEq("R5 stop2", int'(cap[s+10]), 1);
    chkEq("R11 start after two stops", int'(cap[s+11]), 0);
    chkEq("R5 second data", getBits(s + 12, 8), 8'hF0);
  endtask

  task automatic t_disable();
    int s;
    clean(8'h20);
    ctl(9'h030);
    wr(8'h55);
    waitTicks(20);
    chkEq("R6 disable wins, nothing sent", findZero(0), -1);
    chkEq("R6 char kept", fifoEmpty, 0);
    ctl(9'h010);
    waitTicks(16);
    s = findZero(0);
    chkEq("R6 sent after enable", getBits(s + 1, 8), 8'h55);
  endtask

  task automatic t_mid_disable();
    int s;
    clean(8'h20);
    ctl(9'h010);
    wr(8'h81); wr(8'h42);
    waitStart();
    ctl(9'h020);
    waitTicks(25);
    s = findZero(0);
    chkEq("R7 frame intact", getBits(s + 1, 8), 8'h81);
    chkEq("R7 stop", int'(cap[s+9]), 1);
    chkEq("R7 no further frame", findZero(s + 10), -1);
    chkEq("R7 second char kept", fifoEmpty, 0);
  endtask

  task automatic t_break();
    int s, ones;
    clean(8'h20);
    ctl(9'h010);
    ctl(9'h080);
    @(negedge clk);
    chkEq("R8 line low on break", txLine, 0);
    wr(8'h99);
    nb = 0;
    waitTicks(20);
    ones = 0;
    for (int i = 0; i < nb; i++) if (cap[i]) ones++;
    chkEq("R8 held low", ones, 0);
    chkEq("R8 no frame during break", fifoEmpty, 0);
    ctl(9'h180);
    @(negedge clk);
    chkEq("R8 stop wins, line high", txLine, 1);
    nb = 0;
    waitTicks(16);
    s = findZero(0);
    chkEq("R8 sent after break", getBits(s + 1, 8), 8'h99);
    // break issued mid-frame
    nb = 0;
    wr(8'hF3);
    waitStart();
    ctl(9'h080);
    waitTicks(15);
    s = findZero(0);
    chkEq("R8 frame intact", getBits(s + 1, 8), 8'hF3);
    chkEq("R8 stop kept", int'(cap[s+9]), 1);
    chkEq("R8 low after frame", int'(cap[s+10]), 0);
    chkEq("R8 still low", txLine, 0);
  endtask

  task automatic t_flush();
    clean(8'h20);
    wr(8'h01); wr(8'h02); wr(8'h03);
    @(negedge clk);
    chkEq("R9 queued", fifoEmpty, 0);
    ctl(9'h002);
    @(negedge clk);
    chkEq("R9 emptied", fifoEmpty, 1);
    ctl(9'h010);
    nb = 0;
    waitTicks(15);
    chkEq("R9 nothing left to send", findZero(0), -1);
    wr(8'h00);
    waitStart();
    ctl(9'h002);
    @(negedge clk);
    chkEq("R9 abort line high", txLine, 1);
    nb = 0;
    waitTicks(12);
    chkEq("R9 stays idle", findZero(0), -1);
  endtask

  task automatic t_full();
    int pos, s, bad;
    clean(8'h20);
    for (int i = 0; i < 16; i++) wr(8'(i + 1));
    @(negedge clk);
    chkEq("R10 full at 16", fifoFull, 1);
    wr(8'h77);
    @(negedge clk);
    chkEq("R10 still full", fifoFull, 1);
    nb = 0;
    ctl(9'h010);
    waitTicks(175);
    pos = 0; bad = 0;
    for (int i = 0; i < 16; i++) begin
      s = findZero(pos);
      if (s < 0 || getBits(s + 1, 8) != i + 1) bad++;
      pos = (s < 0) ? pos : s + 10;
    end
    chkEq("R10 order of 16 chars", bad, 0);
    chkEq("R10 extra write dropped", findZero(pos), -1);
    chkEq("R10 empty after drain", fifoEmpty, 1);
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_8n1_b2b();
    frameTest("R3 R4 7-bit even", 8'h04, 8'h57, 7, 1, 1, 1, 8'h57);
    frameTest("R3 R4 6-bit odd",  8'h0E, 8'h3F, 6, 1, 1, 1, 8'h3F);
    frameTest("R3 8-bit upper",   8'h20, 8'hC1, 8, 0, 0, 1, 8'hC1);
    frameTest("R4 mark",          8'h18, 8'h00, 8, 1, 1, 1, 8'h00);
    frameTest("R4 space",         8'h10, 8'hFF, 8, 1, 0, 1, 8'hFF);
    frameTest("R4 even 8-bit",    8'h00, 8'h07, 8, 1, 1, 1, 8'h07);
    t_two_stop();
    t_disable();
    t_mid_disable();
    t_break();
    t_flush();
    t_full();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule